// File: doc/BRIEF.md
# Audio Subframe Serializer

This block turns one stereo audio frame into a stream of serial data bits for a consumer digital audio transmitter. A frame is two subframes of 32 slots each, channel A first and then channel B. Each subframe is four preamble slots, then a 27-bit payload sent least significant bit first, then one parity slot. The payload is a 24-bit audio word followed by the validity (V), user (U) and channel-status (C) bits. Preamble patterns and line coding are produced downstream. This block only flags the preamble slots, and it drives its data output low during them.

A host writes a control word, a channel-A audio word and a channel-B audio word with its V/U/C triple. At each frame start, three things happen together. The channel-A audio and the channel-A V/U/C bits from the control word go into the shift register. The channel-B audio and triple are copied into a staging register. A data-empty flag is raised. The staged channel-B word is loaded when channel B starts. A one-cycle slot strobe paces the block.

The stop-mode control bit decides what clearing the enable does. In one setting the transmission is cut at once. In the other, the current frame finishes first.

Top module: `audio_subframe_ser`

## Requirements
- R1: After reset, `ser_bit`, `preamble`, `sub_b`, `slot_idx` and `irq` are 0, `empty` is 1, and the enable, interrupt-enable and stop-mode bits are cleared.
- R2: With the block disabled and `ctrl_wdata[0]`=1 written, the next strobe loads a frame and enters slot 0 of channel A. Slots 0 to 3 of every subframe set `preamble` and drive `ser_bit` low.
- R3: Slots 4 to 27 carry the 24 audio bits, least significant bit first (slot 4 = bit 0).
- R4: Slots 28, 29 and 30 carry V, U and C. For channel A they come from `ctrl_wdata` bits 3, 4 and 5, captured at the frame start. For channel B they come from `b_nad` bits 0, 1 and 2.
- R5: Slot 31 carries even parity: it is the XOR of slots 4 to 30.
- R6: Channel B sends the audio and triple that were staged at its own frame start. Channel-B writes made later in that frame go out in the next frame.
- R7: Each strobe advances `slot_idx` by one. Slot 31 of A is followed by slot 0 of B. Slot 31 of B is followed by slot 0 of A; this transition is the frame boundary.
- R8: With stop mode (`ctrl_wdata[2]`) at 0, clearing the enable returns the block to idle within two clocks, even in the middle of a frame: slot 0, channel A, `ser_bit` low.
- R9: With stop mode at 1, clearing the enable in the middle of a frame lets the frame finish. The boundary strobe then enters idle.
- R10: `empty` sets at each frame load and clears on `a_we` or `b_we`. A write in the same cycle as a load leaves `empty` at 0.
- R11: `irq` is 1 exactly when the interrupt-enable bit (`ctrl_wdata[1]`) is 1 and `empty` is 1.
- R12: `sw_rst` clears the enable, interrupt-enable and stop-mode bits, so transmission stops at once and `irq` drops.
- R13: While idle, strobes leave `slot_idx` at 0 and `sub_b` at 0, and `ser_bit` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| sw_rst | input | 1 | Software reset of the control bits |
| stb | input | 1 | One-cycle slot strobe |
| ctrl_we | input | 1 | Control word write |
| ctrl_wdata | input | 6 | {C_A, U_A, V_A, stop mode, irq enable, enable} |
| a_we | input | 1 | Channel-A audio write |
| a_data | input | 24 | Channel-A audio word |
| b_we | input | 1 | Channel-B audio and triple write |
| b_data | input | 24 | Channel-B audio word |
| b_nad | input | 3 | Channel-B {C, U, V} |
| ser_bit | output | 1 | Serial NRZ data bit for the current slot |
| slot_idx | output | 5 | Current slot number, 0 to 31 |
| sub_b | output | 1 | 1 while channel B is being sent |
| preamble | output | 1 | 1 during slots 0 to 3 of an active subframe |
| empty | output | 1 | Audio data consumed, waiting for new data |
| irq | output | 1 | Interrupt request |

## Verification
The bench sends payloads with every bit set, a single bit set and mixed patterns, so a wrong bit order, a shift that is one slot off, or a V/U/C mix-up shows up as wrong slot values, and a parity computed over the wrong slots flips slot 31. It rewrites channel B in the middle of a frame: a design that read the buffer live instead of from the staged copy would send the new word one frame too early. It clears the enable in both stop modes. A design that ignored stop mode would either cut the frame short or run past the boundary. It also writes audio in the same cycle as a frame load; a design that let the load win would report `empty` when fresh data is present.

// File: rtl/asf_pkg.sv
package asf_pkg;
  localparam int unsigned DEF_AUD_W     = 24;
  localparam int unsigned NAD_W         = 3;   // V, U, C
  localparam int unsigned DEF_PRE_SLOTS = 4;
  // control word bit positions
  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_IE   = 1;
  localparam int unsigned CB_STOP = 2;
  localparam int unsigned CB_NAD  = 3;
  localparam int unsigned CTRL_W  = CB_NAD + NAD_W;
endpackage

// File: rtl/asf_host_regs.sv
module asf_host_regs #(
  parameter int unsigned AUD_W = asf_pkg::DEF_AUD_W,
  localparam int unsigned NAD_W = asf_pkg::NAD_W,
  localparam int unsigned SR_W  = AUD_W + NAD_W,
  localparam int unsigned CW    = asf_pkg::CTRL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_rst,
  input  logic             ctrl_we,
  input  logic [CW-1:0]    ctrl_wdata,
  input  logic             a_we,
  input  logic [AUD_W-1:0] a_data,
  input  logic             b_we,
  input  logic [AUD_W-1:0] b_data,
  input  logic [NAD_W-1:0] b_nad,
  input  logic             frame_ld,
  output logic             en,
  output logic             ie,
  output logic             stopm,
  output logic [SR_W-1:0]  word_a,
  output logic [SR_W-1:0]  word_b,
  output logic             empty,
  output logic             irq
);
  import asf_pkg::*;

  logic             en_q, ie_q, st_q, empty_q, irq_q;
  logic [NAD_W-1:0] nad_a_q, nad_b_q;
  logic [AUD_W-1:0] aud_a_q, aud_b_q;
  logic [SR_W-1:0]  stg_q;
  logic             en_n, ie_n, st_n, empty_n;

  always_comb begin
    en_n = en_q;
    ie_n = ie_q;
    st_n = st_q;
    if (sw_rst) begin
      en_n = 1'b0;
      ie_n = 1'b0;
      st_n = 1'b0;
    end else if (ctrl_we) begin
      en_n = ctrl_wdata[CB_EN];
      ie_n = ctrl_wdata[CB_IE];
      st_n = ctrl_wdata[CB_STOP];
    end
    empty_n = empty_q;
    if (a_we || b_we)  empty_n = 1'b0;
    else if (frame_ld) empty_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      ie_q    <= 1'b0;
      st_q    <= 1'b0;
      empty_q <= 1'b1;
      irq_q   <= 1'b0;
      nad_a_q <= '0;
      nad_b_q <= '0;
      aud_a_q <= '0;
      aud_b_q <= '0;
      stg_q   <= '0;
    end else begin
      en_q    <= en_n;
      ie_q    <= ie_n;
      st_q    <= st_n;
      empty_q <= empty_n;
      irq_q   <= ie_n & empty_n;
      if (ctrl_we && !sw_rst) nad_a_q <= ctrl_wdata[CB_NAD +: NAD_W];
      if (a_we) aud_a_q <= a_data;
      if (b_we) begin
        aud_b_q <= b_data;
        nad_b_q <= b_nad;
      end
      if (frame_ld) stg_q <= {nad_b_q, aud_b_q};
    end
  end

  assign en     = en_q;
  assign ie     = ie_q;
  assign stopm  = st_q;
  assign word_a = {nad_a_q, aud_a_q};
  assign word_b = stg_q;
  assign empty  = empty_q;
  assign irq    = irq_q;

  // R11: request tracks enable and empty flag
  a_r11_irq_track: assert property (@(posedge clk) disable iff (rst)
    irq_q == (ie_q && empty_q));
  // R10: host write clears the flag
  a_r10_write_clears: assert property (@(posedge clk) disable iff (rst)
    (a_we || b_we) |=> !empty_q);
  // R10: load without write sets the flag
  a_r10_load_sets: assert property (@(posedge clk) disable iff (rst)
    (frame_ld && !a_we && !b_we) |=> empty_q);
  // R12: software reset clears the three control bits
  a_r12_swrst: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (!en_q && !ie_q && !st_q));
endmodule

// File: rtl/asf_slot_seq.sv
module asf_slot_seq #(
  parameter int unsigned SLOTS     = 32,
  parameter int unsigned PRE_SLOTS = 4,
  localparam int unsigned SLOT_BW  = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               stopm,
  input  logic               stb,
  output logic [SLOT_BW-1:0] slot_o,
  output logic               sub_o,
  output logic               pre_o,
  output logic               run_o,
  output logic               frame_ld,
  output logic               b_ld,
  output logic               adv,
  output logic               nrun,
  output logic [SLOT_BW-1:0] nslot
);
  localparam logic [SLOT_BW-1:0] LAST    = SLOT_BW'(SLOTS - 1);
  localparam logic [SLOT_BW-1:0] PRE_LIM = SLOT_BW'(PRE_SLOTS);

  logic [SLOT_BW-1:0] slot_q, slot_n;
  logic               sub_q, sub_n, run_q, run_n, pre_q;
  logic               kill, last;

  assign kill = !en && !stopm;
  assign last = (slot_q == LAST);

  always_comb begin
    run_n    = run_q;
    slot_n   = slot_q;
    sub_n    = sub_q;
    frame_ld = 1'b0;
    b_ld     = 1'b0;
    if (kill) begin
      run_n  = 1'b0;
      slot_n = '0;
      sub_n  = 1'b0;
    end else if (stb) begin
      if (!run_q) begin
        if (en) begin
          run_n    = 1'b1;
          frame_ld = 1'b1;
        end
      end else if (last) begin
        slot_n = '0;
        if (!sub_q) begin
          sub_n = 1'b1;
          b_ld  = 1'b1;
        end else begin
          sub_n = 1'b0;
          if (en) frame_ld = 1'b1;
          else    run_n    = 1'b0;
        end
      end else begin
        slot_n = slot_q + 1'b1;
      end
    end
  end

  assign adv   = stb && !kill && run_n;
  assign nrun  = run_n;
  assign nslot = slot_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      sub_q  <= 1'b0;
      run_q  <= 1'b0;
      pre_q  <= 1'b0;
    end else begin
      slot_q <= slot_n;
      sub_q  <= sub_n;
      run_q  <= run_n;
      pre_q  <= run_n && (slot_n < PRE_LIM);
    end
  end

  assign slot_o = slot_q;
  assign sub_o  = sub_q;
  assign pre_o  = pre_q;
  assign run_o  = run_q;

  // R7: ordinary slot step
  a_r7_step: assert property (@(posedge clk) disable iff (rst)
    (stb && run_q && en && !last) |=> (slot_q == $past(slot_q) + 1'b1));
  // R7: frame boundary wraps to channel A slot 0
  a_r7_boundary: assert property (@(posedge clk) disable iff (rst)
    (stb && run_q && en && last && sub_q) |=> (run_q && slot_q == '0 && !sub_q));
  // R8: immediate stop mode
  a_r8_kill: assert property (@(posedge clk) disable iff (rst)
    (!en && !stopm) |=> (!run_q && slot_q == '0 && !sub_q));
  // R9: frame-boundary stop mode keeps running inside a subframe
  a_r9_finish: assert property (@(posedge clk) disable iff (rst)
    (stb && run_q && stopm && !last) |=> run_q);
  // R13: idle parks at channel A slot 0
  a_r13_park: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> (slot_q == '0 && !sub_q && !pre_q));
endmodule

// File: rtl/asf_shifter.sv
module asf_shifter #(
  parameter int unsigned SR_W      = 27,
  parameter int unsigned PRE_SLOTS = 4,
  localparam int unsigned SLOTS    = PRE_SLOTS + SR_W + 1,
  localparam int unsigned SLOT_BW  = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  logic               nrun,
  input  logic [SLOT_BW-1:0] nslot,
  input  logic               frame_ld,
  input  logic               b_ld,
  input  logic [SR_W-1:0]    word_a,
  input  logic [SR_W-1:0]    word_b,
  output logic               ser
);
  localparam logic [SLOT_BW-1:0] DATA_LO = SLOT_BW'(PRE_SLOTS);
  localparam logic [SLOT_BW-1:0] PAR_SL  = SLOT_BW'(PRE_SLOTS + SR_W);

  logic [SR_W-1:0] sr_q;
  logic            par_q, ser_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= '0;
      par_q <= 1'b0;
      ser_q <= 1'b0;
    end else if (!nrun) begin
      sr_q  <= '0;
      par_q <= 1'b0;
      ser_q <= 1'b0;
    end else if (frame_ld) begin
      sr_q  <= word_a;
      par_q <= 1'b0;
      ser_q <= 1'b0;
    end else if (b_ld) begin
      sr_q  <= word_b;
      par_q <= 1'b0;
      ser_q <= 1'b0;
    end else if (adv) begin
      if (nslot >= DATA_LO && nslot < PAR_SL) begin
        ser_q <= sr_q[0];
        par_q <= par_q ^ sr_q[0];
        sr_q  <= sr_q >> 1;
      end else if (nslot == PAR_SL) begin
        ser_q <= par_q;
      end else begin
        ser_q <= 1'b0;
      end
    end
  end

  assign ser = ser_q;

  // R3: every payload bit is consumed before the parity slot
  a_r3_drained: assert property (@(posedge clk) disable iff (rst)
    (adv && !frame_ld && !b_ld && nslot == PAR_SL) |-> (sr_q == '0));
  // R2: preamble slots stay low
  a_r2_pre_quiet: assert property (@(posedge clk) disable iff (rst)
    (adv && nslot < DATA_LO) |=> !ser_q);
endmodule

// File: rtl/audio_subframe_ser.sv
module audio_subframe_ser #(
  parameter int unsigned AUD_W     = asf_pkg::DEF_AUD_W,
  parameter int unsigned PRE_SLOTS = asf_pkg::DEF_PRE_SLOTS,
  localparam int unsigned NAD_W    = asf_pkg::NAD_W,
  localparam int unsigned SR_W     = AUD_W + NAD_W,
  localparam int unsigned SLOTS    = PRE_SLOTS + SR_W + 1,
  localparam int unsigned SLOT_BW  = $clog2(SLOTS),
  localparam int unsigned CW       = asf_pkg::CTRL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sw_rst,
  input  logic               stb,
  input  logic               ctrl_we,
  input  logic [CW-1:0]      ctrl_wdata,
  input  logic               a_we,
  input  logic [AUD_W-1:0]   a_data,
  input  logic               b_we,
  input  logic [AUD_W-1:0]   b_data,
  input  logic [NAD_W-1:0]   b_nad,
  output logic               ser_bit,
  output logic [SLOT_BW-1:0] slot_idx,
  output logic               sub_b,
  output logic               preamble,
  output logic               empty,
  output logic               irq
);
  logic               en, ie, stopm;
  logic [SR_W-1:0]    word_a, word_b;
  logic               frame_ld, b_ld, adv, nrun, run;
  logic [SLOT_BW-1:0] nslot;

  asf_host_regs #(.AUD_W(AUD_W)) u_regs (
    .clk(clk), .rst(rst), .sw_rst(sw_rst),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .a_we(a_we), .a_data(a_data),
    .b_we(b_we), .b_data(b_data), .b_nad(b_nad),
    .frame_ld(frame_ld),
    .en(en), .ie(ie), .stopm(stopm),
    .word_a(word_a), .word_b(word_b),
    .empty(empty), .irq(irq)
  );

  asf_slot_seq #(.SLOTS(SLOTS), .PRE_SLOTS(PRE_SLOTS)) u_seq (
    .clk(clk), .rst(rst), .en(en), .stopm(stopm), .stb(stb),
    .slot_o(slot_idx), .sub_o(sub_b), .pre_o(preamble), .run_o(run),
    .frame_ld(frame_ld), .b_ld(b_ld), .adv(adv), .nrun(nrun), .nslot(nslot)
  );

  asf_shifter #(.SR_W(SR_W), .PRE_SLOTS(PRE_SLOTS)) u_shf (
    .clk(clk), .rst(rst), .adv(adv), .nrun(nrun), .nslot(nslot),
    .frame_ld(frame_ld), .b_ld(b_ld),
    .word_a(word_a), .word_b(word_b), .ser(ser_bit)
  );

  // R13: serial output low while idle
  a_r13_low_idle: assert property (@(posedge clk) disable iff (rst)
    !run |-> !ser_bit);
  // R2: serial output low in preamble slots
  a_r2_pre_low: assert property (@(posedge clk) disable iff (rst)
    preamble |-> !ser_bit);
endmodule

// File: tb/audio_subframe_ser_test.sv
module audio_subframe_ser_test;
  typedef struct packed {
    logic       ser;
    logic [4:0] slot;
    logic       sub;
    logic       pre;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_rst = 1'b0;
  logic        stb = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [5:0]  ctrl_wdata = '0;
  logic        a_we = 1'b0;
  logic [23:0] a_data = '0;
  logic        b_we = 1'b0;
  logic [23:0] b_data = '0;
  logic [2:0]  b_nad = '0;
  logic        ser_bit, sub_b, preamble, empty, irq;
  logic [4:0]  slot_idx;

  int total = 0;
  int bad = 0;
  item_t exp_q[$];
  logic samp = 1'b0;

  always #5 clk = ~clk;

  audio_subframe_ser uut (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .stb(stb),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .a_we(a_we), .a_data(a_data), .b_we(b_we), .b_data(b_data), .b_nad(b_nad),
    .ser_bit(ser_bit), .slot_idx(slot_idx), .sub_b(sub_b),
    .preamble(preamble), .empty(empty), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // vuc[0]=V, vuc[1]=U, vuc[2]=C
  function automatic logic exp_bit(input logic [23:0] aud, input logic [2:0] vuc, input int s);
    if (s < 4)  return 1'b0;
    if (s < 28) return aud[s-4];
    if (s < 31) return vuc[s-28];
    return (^aud) ^ (^vuc);
  endfunction

  function automatic string tag_of(input item_t e);
    if (!e.pre && e.slot == 0 && !e.sub) return "R13 R8 R9 R12 idle";
    if (e.slot < 4)                      return "R2 R7 preamble";
    if (e.sub && e.slot < 31)            return "R6 R3 R4 channel B";
    if (e.slot < 28)                     return "R3 audio";
    if (e.slot < 31)                     return "R4 VUC";
    return "R5 parity";
  endfunction

  // monitor: pops expected items after each strobe edge
  always @(posedge clk) samp <= stb;
  always @(negedge clk) begin
    if (samp) begin
      item_t got, e;
      got = '{ser: ser_bit, slot: slot_idx, sub: sub_b, pre: preamble};
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R7 unexpected slot act=%0h exp=none", got);
      end else begin
        e = exp_q.pop_front();
        if (got !== e) begin
          bad++;
          $display("FAIL %s act=%0h exp=%0h", tag_of(e), got, e);
        end
      end
    end
  end

  // driver
  task automatic step(input item_t e);
    exp_q.push_back(e);
    @(negedge clk) stb = 1'b1;
    @(negedge clk) stb = 1'b0;
  endtask

  task automatic idle_step();
    step('0);
  endtask

  task automatic frame_part(input logic [23:0] aa, input logic [2:0] va,
                            input logic [23:0] ab, input logic [2:0] vb,
                            input int from, input int to);
    for (int g = from; g <= to; g++) begin
      item_t e;
      int s;
      logic sb;
      s  = g % 32;
      sb = (g >= 32);
      e.ser  = sb ? exp_bit(ab, vb, s) : exp_bit(aa, va, s);
      e.slot = 5'(s);
      e.sub  = sb;
      e.pre  = (s < 4);
      step(e);
    end
  endtask

  task automatic wr_ctrl(input logic [5:0] d);
    @(negedge clk) begin ctrl_we = 1'b1; ctrl_wdata = d; end
    @(negedge clk) ctrl_we = 1'b0;
  endtask

  task automatic wr_a(input logic [23:0] d);
    @(negedge clk) begin a_we = 1'b1; a_data = d; end
    @(negedge clk) a_we = 1'b0;
  endtask

  task automatic wr_b(input logic [23:0] d, input logic [2:0] v);
    @(negedge clk) begin b_we = 1'b1; b_data = d; b_nad = v; end
    @(negedge clk) b_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [23:0] a1, a2, a3, b1, b2, b3;
    a1 = 24'hA53C0F; b1 = 24'h000001;
    a2 = 24'hFFFFFF; b2 = 24'h123456;
    a3 = 24'h800001; b3 = 24'h0F0F0F;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ser_bit", 32'(ser_bit), 0);
    chk("R1 slot_idx", 32'(slot_idx), 0);
    chk("R1 sub_b", 32'(sub_b), 0);
    chk("R1 preamble", 32'(preamble), 0);
    chk("R1 empty", 32'(empty), 1);
    chk("R1 irq", 32'(irq), 0);
    // R13: strobes while disabled
    idle_step();
    idle_step();
    // enable, irq enable, stop mode 1, A triple V=1 U=0 C=1
    wr_ctrl(6'b101_111);
    wr_a(a1);
    wr_b(b1, 3'b010);
    chk("R10 empty after write", 32'(empty), 0);
    chk("R11 irq with data", 32'(irq), 0);
    frame_part(a1, 3'b101, b1, 3'b010, 0, 0);
    chk("R10 empty at load", 32'(empty), 1);
    chk("R11 irq at load", 32'(irq), 1);
    frame_part(a1, 3'b101, b1, 3'b010, 1, 19);
    // R6: new B data mid-frame must wait for next frame
    wr_a(a2);
    wr_b(b2, 3'b111);
    chk("R10 empty cleared", 32'(empty), 0);
    chk("R11 irq cleared", 32'(irq), 0);
    frame_part(a1, 3'b101, b1, 3'b010, 20, 63);
    frame_part(a2, 3'b101, b2, 3'b111, 0, 40);
    // R9: disable with stop mode 1, frame completes
    wr_ctrl(6'b101_110);
    frame_part(a2, 3'b101, b2, 3'b111, 41, 63);
    idle_step();
    idle_step();
    // R8: stop mode 0, A triple U=1
    wr_ctrl(6'b010_001);
    wr_a(a3);
    wr_b(b3, 3'b001);
    frame_part(a3, 3'b010, b3, 3'b001, 0, 9);
    wr_ctrl(6'b010_000);
    repeat (2) @(negedge clk);
    chk("R8 slot_idx after cut", 32'(slot_idx), 0);
    chk("R8 sub_b after cut", 32'(sub_b), 0);
    chk("R8 ser_bit after cut", 32'(ser_bit), 0);
    chk("R8 preamble after cut", 32'(preamble), 0);
    idle_step();
    chk("R11 irq with ie clear", 32'(irq), 0);
    // R10: write in the same cycle as the frame load
    wr_ctrl(6'b010_001);
    @(negedge clk) begin stb = 1'b1; a_we = 1'b1; a_data = 24'h55AA55; end
    exp_q.push_back('{ser: 1'b0, slot: 5'd0, sub: 1'b0, pre: 1'b1});
    @(negedge clk) begin stb = 1'b0; a_we = 1'b0; end
    chk("R10 write wins over load", 32'(empty), 0);
    frame_part(a3, 3'b010, b3, 3'b001, 1, 7);
    // R12: software reset while running in stop mode 1
    wr_ctrl(6'b010_111);
    @(negedge clk) sw_rst = 1'b1;
    @(negedge clk) sw_rst = 1'b0;
    @(negedge clk);
    chk("R12 slot_idx", 32'(slot_idx), 0);
    chk("R12 preamble", 32'(preamble), 0);
    chk("R12 ser_bit", 32'(ser_bit), 0);
    chk("R12 irq", 32'(irq), 0);
    idle_step();
    repeat (4) @(negedge clk);
    chk("R7 all expected slots seen", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule